// File: doc/BRIEF.md
# Thermal Range Throttle Controller

This block watches a stream of signed die-temperature samples and keeps the thermal policy for a processor clock domain. Each sample is presented with a one-cycle valid strobe. The block then moves a small range machine with four states: not yet classified, free-running, voltage-limited and throttling. It moves by at most one range per sample. Separate hysteresis applies when falling back across each of the two trip points.

For every range the block reports two values for the next out-of-window interrupt, a lower and an upper temperature threshold. It also reports which polling interval the sensor driver should use. While the block is in the throttling range it holds a frequency cap. Each sample that carries an update flag lowers the cap by a fixed step, and the cap stops at a floor. Leaving that range puts the cap back at its ceiling. The requested processor frequency is clamped by the cap in the two limited ranges and passes through unchanged when free-running.

The range state uses a three-bit code. Any code outside the four legal values drops back to the unclassified state on the next sample, and in that state both thresholds show the "unspecified" code. Trip points, hysteresis, step, ceiling and floor are static configuration inputs. The floor is meant to be set to the ceiling divided by a fixed ratio, and it must stay larger than one step.

Top module: `thermal_throttle`

## Requirements
- R1: During and right after reset, rangeState is 0 (unclassified), both thresholds hold the unspecified code UNSPEC_TEMP (the most negative temperature code), pollSel is 0, and capFreq and outFreq are 0.
- R2: On the first sample after reset the range becomes voltage-limited (code 2) if tempC >= cfgLowTrip. Otherwise it becomes free-running (code 1).
- R3: From free-running (code 1), a sample with tempC >= cfgLowTrip moves to voltage-limited (code 2). Any lower sample keeps free-running.
- R4: From voltage-limited, a sample with tempC <= cfgLowTrip - cfgHyst moves to free-running. Otherwise a sample with tempC >= cfgHighTrip moves to throttling (code 3). Otherwise the range stays.
- R5: From throttling, a sample with tempC <= cfgHighTrip - cfgHyst moves to voltage-limited. The range never moves more than one step per sample, however far the temperature jumps.
- R6: The thresholds follow the new range. Free-running gives SENSOR_MIN and cfgLowTrip. Voltage-limited gives cfgLowTrip - cfgHyst and cfgHighTrip. Throttling gives cfgHighTrip - cfgHyst and SENSOR_MAX.
- R7: pollSel is 3 (critical) in throttling whatever intrMode is. When intrMode is 0, pollSel is 2 (fast) in voltage-limited and 1 (slow) in free-running. When intrMode is 1, pollSel is 0 (no polling) in both of those ranges.
- R8: In throttling, a sample with updateFlag set lowers capFreq by cfgStep but never below cfgMinCap. A sample without the flag keeps capFreq, raised to cfgMinCap if it is lower.
- R9: A sample whose new range is not throttling sets capFreq to cfgMaxCap.
- R10: outFreq is min(reqFreq, new cap) when the new range is voltage-limited or throttling, and reqFreq unchanged when it is free-running.
- R11: All outputs change only on the clock edge where tempValid is high, and they are registered on that edge. Without the strobe, changes on tempC, updateFlag or reqFreq leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tempValid | input | 1 | One-cycle strobe marking a temperature sample |
| tempC | input | TEMP_W | Signed temperature sample |
| updateFlag | input | 1 | Requests one cap step on this sample while throttling |
| intrMode | input | 1 | 1 when the sensor delivers threshold interrupts, 0 when polled |
| reqFreq | input | FREQ_W | Requested processor frequency |
| cfgLowTrip | input | TEMP_W | Signed lower trip temperature |
| cfgHighTrip | input | TEMP_W | Signed upper trip temperature |
| cfgHyst | input | TEMP_W | Unsigned hysteresis applied when falling back |
| cfgStep | input | FREQ_W | Cap decrement per update |
| cfgMaxCap | input | FREQ_W | Cap ceiling |
| cfgMinCap | input | FREQ_W | Cap floor |
| rangeState | output | 3 | Current range code (0 to 3) |
| thrLow | output | TEMP_W | Signed lower interrupt threshold |
| thrHigh | output | TEMP_W | Signed upper interrupt threshold |
| pollSel | output | 2 | Polling interval: 0 none, 1 slow, 2 fast, 3 critical |
| capFreq | output | FREQ_W | Current frequency cap |
| outFreq | output | FREQ_W | Granted processor frequency |

## Verification
The range, both thresholds, the poll selection, the cap and the granted frequency are all registered on the same edge that sees tempValid high. So every result is due exactly one clock edge after the strobe and stays put until the next strobe. The bench drives each sample on a falling edge and removes the strobe on the next falling edge. It compares a behavioural model against every output on each falling edge, and it makes the directed checks at the falling edge that follows the capturing rising edge. Idle periods between samples are also compared every cycle, so any output that moves without a strobe is reported.

// File: rtl/thr_pkg.sv
package thr_pkg;

  typedef enum logic [2:0] {
    RNG_UNKNOWN = 3'd0,
    RNG_FREE    = 3'd1,
    RNG_VLIM    = 3'd2,
    RNG_THROT   = 3'd3
  } rangeT;

  typedef enum logic [1:0] {
    POLL_NONE = 2'd0,
    POLL_SLOW = 2'd1,
    POLL_FAST = 2'd2,
    POLL_CRIT = 2'd3
  } pollT;

  typedef enum logic [1:0] {
    CAP_RESTORE = 2'd0,
    CAP_FLOOR   = 2'd1,
    CAP_STEP    = 2'd2
  } capModeT;

  typedef struct packed {
    logic    load;
    rangeT   rng;
    capModeT capMode;
    logic    clampOut;
  } ctrlT;

endpackage

// File: rtl/thr_range_ctrl.sv
module thr_range_ctrl
  import thr_pkg::*;
#(
  parameter int TEMP_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tempValid,
  input  logic [TEMP_W-1:0] tempC,
  input  logic              updateFlag,
  input  logic [TEMP_W-1:0] cfgLowTrip,
  input  logic [TEMP_W-1:0] cfgHighTrip,
  input  logic [TEMP_W-1:0] cfgHyst,
  output rangeT             rangeQ,
  output ctrlT              ctl
);

  // two guard bits keep (trip - hysteresis) free of overflow
  localparam int EW = TEMP_W + 2;

  logic signed [EW-1:0] tempE, lowE, highE, hystE, lowRelE, highRelE;
  logic atLow, belowLowRel, atHigh, belowHighRel;
  rangeT nxtRange;

  always_comb begin
    tempE    = {{2{tempC[TEMP_W-1]}}, tempC};
    lowE     = {{2{cfgLowTrip[TEMP_W-1]}}, cfgLowTrip};
    highE    = {{2{cfgHighTrip[TEMP_W-1]}}, cfgHighTrip};
    hystE    = {2'b00, cfgHyst};
    lowRelE  = lowE - hystE;
    highRelE = highE - hystE;
  end

  assign atLow        = (tempE >= lowE);
  assign belowLowRel  = (tempE <= lowRelE);
  assign atHigh       = (tempE >= highE);
  assign belowHighRel = (tempE <= highRelE);

  // one range step per sample; unknown resolves to free-running and may
  // continue to voltage-limited on the same sample
  always_comb begin
    case (rangeQ)
      RNG_UNKNOWN: nxtRange = atLow ? RNG_VLIM : RNG_FREE;
      RNG_FREE:    nxtRange = atLow ? RNG_VLIM : RNG_FREE;
      RNG_VLIM: begin
        if (belowLowRel)      nxtRange = RNG_FREE;
        else if (atHigh)      nxtRange = RNG_THROT;
        else                  nxtRange = RNG_VLIM;
      end
      RNG_THROT:   nxtRange = belowHighRel ? RNG_VLIM : RNG_THROT;
      default:     nxtRange = RNG_UNKNOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rangeQ <= RNG_UNKNOWN;
    end else if (tempValid) begin
      rangeQ <= nxtRange;
    end
  end

  always_comb begin
    ctl.load     = tempValid;
    ctl.rng      = nxtRange;
    if (nxtRange == RNG_THROT) begin
      ctl.capMode = updateFlag ? CAP_STEP : CAP_FLOOR;
    end else begin
      ctl.capMode = CAP_RESTORE;
    end
    ctl.clampOut = (nxtRange == RNG_VLIM) || (nxtRange == RNG_THROT);
  end

  // R11: no strobe, no range movement
  a_r11_range_hold: assert property (@(posedge clk) disable iff (!rstN)
    !tempValid |=> $stable(rangeQ));

  // R2: a sample always leaves the unclassified state
  a_r2_classified: assert property (@(posedge clk) disable iff (!rstN)
    (tempValid && rangeQ == RNG_UNKNOWN) |=> (rangeQ == RNG_FREE || rangeQ == RNG_VLIM));

  // R3: free-running can only stay or rise one step
  a_r3_free_step: assert property (@(posedge clk) disable iff (!rstN)
    (tempValid && rangeQ == RNG_FREE) |=> (rangeQ == RNG_FREE || rangeQ == RNG_VLIM));

  // R4: crossing the high trip from voltage-limited enters throttling
  a_r4_enter_throttle: assert property (@(posedge clk) disable iff (!rstN)
    (tempValid && rangeQ == RNG_VLIM && atHigh && !belowLowRel) |=> rangeQ == RNG_THROT);

  // R5: throttling falls back by one step at most
  a_r5_one_step: assert property (@(posedge clk) disable iff (!rstN)
    (tempValid && rangeQ == RNG_THROT) |=> (rangeQ == RNG_THROT || rangeQ == RNG_VLIM));

endmodule

// File: rtl/thr_datapath.sv
module thr_datapath
  import thr_pkg::*;
#(
  parameter int TEMP_W     = 10,
  parameter int FREQ_W     = 16,
  parameter int SENSOR_MIN = -100,
  parameter int SENSOR_MAX = 150
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctl,
  input  logic              intrMode,
  input  logic [FREQ_W-1:0] reqFreq,
  input  logic [TEMP_W-1:0] cfgLowTrip,
  input  logic [TEMP_W-1:0] cfgHighTrip,
  input  logic [TEMP_W-1:0] cfgHyst,
  input  logic [FREQ_W-1:0] cfgStep,
  input  logic [FREQ_W-1:0] cfgMaxCap,
  input  logic [FREQ_W-1:0] cfgMinCap,
  output logic [TEMP_W-1:0] thrLowQ,
  output logic [TEMP_W-1:0] thrHighQ,
  output pollT              pollQ,
  output logic [FREQ_W-1:0] capQ,
  output logic [FREQ_W-1:0] outQ
);

  localparam logic [TEMP_W-1:0] UNSPEC   = {1'b1, {(TEMP_W-1){1'b0}}};
  localparam logic [TEMP_W-1:0] SMIN     = TEMP_W'(SENSOR_MIN);
  localparam logic [TEMP_W-1:0] SMAX     = TEMP_W'(SENSOR_MAX);
  localparam int               CW       = FREQ_W + 1;

  logic [TEMP_W-1:0] thrLowNxt, thrHighNxt;
  pollT              pollNxt;
  logic [FREQ_W-1:0] capNxt, outNxt, capStepped, capFloored;
  logic [CW-1:0]     floorPlusStep;

  // window around the new range
  always_comb begin
    case (ctl.rng)
      RNG_FREE: begin
        thrLowNxt  = SMIN;
        thrHighNxt = cfgLowTrip;
        pollNxt    = intrMode ? POLL_NONE : POLL_SLOW;
      end
      RNG_VLIM: begin
        thrLowNxt  = cfgLowTrip - cfgHyst;
        thrHighNxt = cfgHighTrip;
        pollNxt    = intrMode ? POLL_NONE : POLL_FAST;
      end
      RNG_THROT: begin
        thrLowNxt  = cfgHighTrip - cfgHyst;
        thrHighNxt = SMAX;
        pollNxt    = POLL_CRIT;
      end
      default: begin
        thrLowNxt  = UNSPEC;
        thrHighNxt = UNSPEC;
        pollNxt    = POLL_NONE;
      end
    endcase
  end

  // saturating step toward the floor
  assign floorPlusStep = {1'b0, cfgMinCap} + {1'b0, cfgStep};
  assign capStepped    = ({1'b0, capQ} >= floorPlusStep) ? (capQ - cfgStep) : cfgMinCap;
  assign capFloored    = (capQ < cfgMinCap) ? cfgMinCap : capQ;

  always_comb begin
    case (ctl.capMode)
      CAP_STEP:  capNxt = capStepped;
      CAP_FLOOR: capNxt = capFloored;
      default:   capNxt = cfgMaxCap;
    endcase
  end

  always_comb begin
    if (ctl.clampOut && (capNxt < reqFreq)) begin
      outNxt = capNxt;
    end else begin
      outNxt = reqFreq;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrLowQ  <= UNSPEC;
      thrHighQ <= UNSPEC;
      pollQ    <= POLL_NONE;
      capQ     <= '0;
      outQ     <= '0;
    end else if (ctl.load) begin
      thrLowQ  <= thrLowNxt;
      thrHighQ <= thrHighNxt;
      pollQ    <= pollNxt;
      capQ     <= capNxt;
      outQ     <= outNxt;
    end
  end

  // R8: a throttling sample never leaves the cap under the floor
  a_r8_floor: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.capMode != CAP_RESTORE) |=> capQ >= $past(cfgMinCap));

  // R8: a stepping sample moves by exactly one step or lands on the floor
  a_r8_step_size: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.capMode == CAP_STEP) |=>
      (capQ == $past(cfgMinCap) || ({1'b0, capQ} + {1'b0, $past(cfgStep)}) == {1'b0, $past(capQ)}));

  // R9: any non-throttling sample restores the ceiling
  a_r9_restore: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.capMode == CAP_RESTORE) |=> capQ == $past(cfgMaxCap));

  // R7: throttling always polls at the critical rate
  a_r7_critical: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.rng == RNG_THROT) |=> pollQ == POLL_CRIT);

  // R10: a clamped grant never exceeds the cap
  a_r10_clamp: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.clampOut) |=> outQ <= capQ);

  // R11: outputs hold between samples
  a_r11_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(capQ) && $stable(outQ) && $stable(thrLowQ) && $stable(pollQ)));

endmodule

// File: rtl/thermal_throttle.sv
module thermal_throttle
  import thr_pkg::*;
#(
  parameter int TEMP_W     = 10,
  parameter int FREQ_W     = 16,
  parameter int SENSOR_MIN = -100,
  parameter int SENSOR_MAX = 150
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tempValid,
  input  logic [TEMP_W-1:0] tempC,
  input  logic              updateFlag,
  input  logic              intrMode,
  input  logic [FREQ_W-1:0] reqFreq,
  input  logic [TEMP_W-1:0] cfgLowTrip,
  input  logic [TEMP_W-1:0] cfgHighTrip,
  input  logic [TEMP_W-1:0] cfgHyst,
  input  logic [FREQ_W-1:0] cfgStep,
  input  logic [FREQ_W-1:0] cfgMaxCap,
  input  logic [FREQ_W-1:0] cfgMinCap,
  output logic [2:0]        rangeState,
  output logic [TEMP_W-1:0] thrLow,
  output logic [TEMP_W-1:0] thrHigh,
  output logic [1:0]        pollSel,
  output logic [FREQ_W-1:0] capFreq,
  output logic [FREQ_W-1:0] outFreq
);

  rangeT rangeQ;
  ctrlT  ctl;
  pollT  pollQ;

  thr_range_ctrl #(.TEMP_W(TEMP_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .tempValid   (tempValid),
    .tempC       (tempC),
    .updateFlag  (updateFlag),
    .cfgLowTrip  (cfgLowTrip),
    .cfgHighTrip (cfgHighTrip),
    .cfgHyst     (cfgHyst),
    .rangeQ      (rangeQ),
    .ctl         (ctl)
  );

  thr_datapath #(
    .TEMP_W     (TEMP_W),
    .FREQ_W     (FREQ_W),
    .SENSOR_MIN (SENSOR_MIN),
    .SENSOR_MAX (SENSOR_MAX)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .intrMode    (intrMode),
    .reqFreq     (reqFreq),
    .cfgLowTrip  (cfgLowTrip),
    .cfgHighTrip (cfgHighTrip),
    .cfgHyst     (cfgHyst),
    .cfgStep     (cfgStep),
    .cfgMaxCap   (cfgMaxCap),
    .cfgMinCap   (cfgMinCap),
    .thrLowQ     (thrLow),
    .thrHighQ    (thrHigh),
    .pollQ       (pollQ),
    .capQ        (capFreq),
    .outQ        (outFreq)
  );

  assign rangeState = rangeQ;
  assign pollSel    = pollQ;

endmodule

// File: tb/tb_thermal_throttle.sv
module tb_thermal_throttle;

  localparam int TW = 10;
  localparam int FW = 16;
  localparam int SMIN = -100;
  localparam int SMAX = 150;
  localparam int UNSPEC = -512;
  localparam int LOWT = 60, HIGHT = 80, HYST = 5;
  localparam int STEP = 100, MAXC = 1000, MINC = 250;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tempValid = 1'b0;
  logic [TW-1:0] tempC = '0;
  logic updateFlag = 1'b0;
  logic intrMode = 1'b0;
  logic [FW-1:0] reqFreq = '0;
  logic [2:0] rangeState;
  logic [TW-1:0] thrLow, thrHigh;
  logic [1:0] pollSel;
  logic [FW-1:0] capFreq, outFreq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  thermal_throttle #(.TEMP_W(TW), .FREQ_W(FW), .SENSOR_MIN(SMIN), .SENSOR_MAX(SMAX)) dut (
    .clk(clk), .rstN(rstN), .tempValid(tempValid), .tempC(tempC),
    .updateFlag(updateFlag), .intrMode(intrMode), .reqFreq(reqFreq),
    .cfgLowTrip(TW'(LOWT)), .cfgHighTrip(TW'(HIGHT)), .cfgHyst(TW'(HYST)),
    .cfgStep(FW'(STEP)), .cfgMaxCap(FW'(MAXC)), .cfgMinCap(FW'(MINC)),
    .rangeState(rangeState), .thrLow(thrLow), .thrHigh(thrHigh),
    .pollSel(pollSel), .capFreq(capFreq), .outFreq(outFreq)
  );

  // behavioural reference
  int mRange, mLow, mHigh, mPoll, mCap, mOut;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRange = 0; mLow = UNSPEC; mHigh = UNSPEC; mPoll = 0; mCap = 0; mOut = 0;
    end else if (tempValid) begin
      int t;
      t = int'($signed(tempC));
      if (mRange == 0) mRange = 1;
      if (mRange == 1) begin
        if (t >= LOWT) mRange = 2;
      end else if (mRange == 2) begin
        if (t <= LOWT - HYST) mRange = 1;
        else if (t >= HIGHT) mRange = 3;
      end else if (mRange == 3) begin
        if (t <= HIGHT - HYST) mRange = 2;
      end
      if (mRange == 3) begin
        if (updateFlag) mCap = mCap - STEP;
        if (mCap < MINC) mCap = MINC;
      end else begin
        mCap = MAXC;
      end
      case (mRange)
        1: begin mLow = SMIN; mHigh = LOWT; mPoll = intrMode ? 0 : 1; end
        2: begin mLow = LOWT - HYST; mHigh = HIGHT; mPoll = intrMode ? 0 : 2; end
        default: begin mLow = HIGHT - HYST; mHigh = SMAX; mPoll = 3; end
      endcase
      mOut = (mRange != 1 && mCap < int'(reqFreq)) ? mCap : int'(reqFreq);
    end
  end

  task automatic check(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(int'(rangeState), mRange, "R4", "model range");
      check(int'($signed(thrLow)), mLow, "R6", "model thrLow");
      check(int'($signed(thrHigh)), mHigh, "R6", "model thrHigh");
      check(int'(pollSel), mPoll, "R7", "model pollSel");
      check(int'(capFreq), mCap, "R8", "model capFreq");
      check(int'(outFreq), mOut, "R10", "model outFreq");
    end
  end

  task automatic sample(input int t, input bit upd, input int req);
    @(negedge clk);
    tempValid = 1'b1;
    tempC = TW'(t);
    updateFlag = upd;
    reqFreq = FW'(req);
    @(negedge clk);
    tempValid = 1'b0;
    updateFlag = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(int'(rangeState), 0, "R1", "reset range");
    check(int'($signed(thrLow)), UNSPEC, "R1", "reset thrLow");
    check(int'($signed(thrHigh)), UNSPEC, "R1", "reset thrHigh");
    check(int'(pollSel), 0, "R1", "reset poll");
    check(int'(capFreq), 0, "R1", "reset cap");
    check(int'(outFreq), 0, "R1", "reset out");
    rstN = 1'b1;

    // R2 first sample below trip -> free-running; R10 passthrough
    sample(20, 0, 2000);
    check(int'(rangeState), 1, "R2", "first sample low");
    check(int'($signed(thrLow)), SMIN, "R6", "free thrLow");
    check(int'($signed(thrHigh)), LOWT, "R6", "free thrHigh");
    check(int'(pollSel), 1, "R7", "free polled slow");
    check(int'(outFreq), 2000, "R10", "free passthrough");

    // R3 boundary
    sample(59, 0, 2000);
    check(int'(rangeState), 1, "R3", "59 stays free");
    sample(60, 0, 2000);
    check(int'(rangeState), 2, "R3", "60 enters vlim");
    check(int'($signed(thrLow)), LOWT - HYST, "R6", "vlim thrLow");
    check(int'(pollSel), 2, "R7", "vlim polled fast");
    check(int'(capFreq), MAXC, "R9", "vlim cap at max");
    check(int'(outFreq), MAXC, "R10", "vlim clamps request");

    // R7 interrupt mode
    intrMode = 1'b1;
    sample(70, 0, 500);
    check(int'(pollSel), 0, "R7", "vlim interrupt mode no poll");
    check(int'(outFreq), 500, "R10", "request below cap");

    // R4 falling boundary
    sample(56, 0, 500);
    check(int'(rangeState), 2, "R4", "56 stays vlim");
    sample(55, 0, 500);
    check(int'(rangeState), 1, "R4", "55 drops to free");
    check(int'(pollSel), 0, "R7", "free interrupt mode no poll");
    sample(65, 0, 500);
    sample(80, 1, 2000);
    check(int'(rangeState), 3, "R4", "80 enters throttle");
    check(int'(capFreq), MAXC - STEP, "R8", "first step on entry");
    check(int'(pollSel), 3, "R7", "throttle critical in intr mode");
    check(int'($signed(thrHigh)), SMAX, "R6", "throttle thrHigh");

    // R8 hold without flag, then step to floor
    sample(90, 0, 2000);
    check(int'(capFreq), MAXC - STEP, "R8", "no flag holds cap");
    for (int i = 0; i < 8; i++) sample(90, 1, 2000);
    check(int'(capFreq), MINC, "R8", "cap stops at floor");
    sample(90, 0, 200);
    check(int'(outFreq), 200, "R10", "request under floor");

    // R11 no strobe, inputs wiggle
    @(negedge clk);
    tempC = TW'(-50);
    updateFlag = 1'b1;
    reqFreq = 16'd7;
    repeat (4) @(negedge clk);
    check(int'(rangeState), 3, "R11", "range held without strobe");
    check(int'(capFreq), MINC, "R11", "cap held without strobe");
    check(int'(outFreq), 200, "R11", "out held without strobe");
    updateFlag = 1'b0;

    // R5 jump from throttle falls one step only; R9 restore
    sample(-50, 0, 2000);
    check(int'(rangeState), 2, "R5", "one step down from throttle");
    check(int'(capFreq), MAXC, "R9", "cap restored on exit");
    sample(85, 0, 2000);
    sample(76, 0, 2000);
    check(int'(rangeState), 3, "R5", "76 stays throttle");
    sample(75, 0, 2000);
    check(int'(rangeState), 2, "R5", "75 leaves throttle");

    // R2 first sample at trip goes straight to vlim
    intrMode = 1'b0;
    doReset();
    check(int'(rangeState), 0, "R1", "range after second reset");
    sample(70, 0, 3000);
    check(int'(rangeState), 2, "R2", "first sample hot");
    check(int'(outFreq), MAXC, "R10", "hot first sample clamped");

    repeat (3) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

endmodule